// File: doc/BRIEF.md
# Serial Register Programmer with Unlock Guard

This block takes register-programming words from a slow two-wire serial link, one wire a clock and the other data, and turns each valid word into a single write to one of eight target registers. Both wires are asynchronous to the system clock. They pass through synchronizers, and their edges are found in the system-clock domain.

The link stays closed until the data wire shows an unlock pattern. That pattern is a run of serial-clock rising edges with data high, then one rising edge with data low. After unlock, every bit travels as a pair: its inverse is sampled on the serial-clock falling edge and its true value on the next rising edge. A word is a start bit, then 21 data bits, then a 3-bit register address, and it ends with a load command. A line-activity watchdog closes the link if the sender pauses too long. A power-down input keeps the link closed.

Top module: `serial_reg_prog`

## Requirements
- R1: After a synchronous reset, `wr_stb` and `err_stb` are low and `wr_data` and `wr_addr` are zero.
- R2: The link opens only after at least `UNLOCK_ONES` (default 5) consecutive serial-clock rising edges with data high, directly followed by one rising edge with data low. Any number of high edges at or above that count is accepted. With fewer high edges, a complete word that follows produces neither a write nor an error.
- R3: Bits are sent least significant first. The 21 data bits come first and the 3 address bits follow. A valid word followed by a load command gives a one-cycle `wr_stb` pulse, with the data on `wr_data` and the address on `wr_addr`.
- R4: A bit is valid when the data value at the preceding falling edge is the inverse of the value at the rising edge. A pair that is low at both edges gives a one-cycle `err_stb` pulse and closes the link.
- R5: The load command is data high at both the falling edge and the rising edge. If the number of data and address bits received is not exactly 24, the load command gives `err_stb` and no write.
- R6: If no transition appears on either wire for `WDOG_CYCLES` system clocks, the link closes and the partial word is dropped. Pauses shorter than that limit are harmless.
- R7: Every load command closes the link again, so a word sent without a new unlock pattern is ignored.
- R8: While `pwr_down` is high the link is closed and the serial wires have no effect.
- R9: The start bit must be a valid pair carrying `START_VAL` (default 0). A valid pair carrying the other value closes the link without an error pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | Power-down, holds the link closed |
| ser_clk | input | 1 | Serial clock wire (asynchronous) |
| ser_dat | input | 1 | Serial data wire (asynchronous) |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_data | output | 21 | Data of the last valid word |
| wr_addr | output | 3 | Target register of the last valid word |
| err_stb | output | 1 | One-cycle error pulse |

## Verification
The internal link state is visible only through strobes, so a wrong state shows at the ports as a write or error pulse that is missing or not expected. That pulse appears a few system clocks after the serial rising edge of the load command or of the faulty bit. A link that stays open when it should close shows as a spurious write on a later word sent without an unlock pattern. Wrong shift order or a wrong bit count shows in the `wr_data`/`wr_addr` values of the very next strobe.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_START  = 2'd1,
    ST_SHIFT  = 2'd2
  } srp_state_e;
endpackage

// File: rtl/srp_line_sync.sv
module srp_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], line_in};
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];
  assign fall  = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/srp_watchdog.sv
module srp_watchdog #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic activity,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] idle_cnt;

  assign expire = !activity && (idle_cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst)                         idle_cnt <= '0;
    else if (activity)               idle_cnt <= '0;
    else if (idle_cnt != CW'(LIMIT)) idle_cnt <= idle_cnt + 1'b1;
  end

  p_single_expire_r6: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire);
endmodule

// File: rtl/srp_frame_core.sv
module srp_frame_core
  import srp_pkg::*;
#(
  parameter int   DATA_W      = 21,
  parameter int   ADDR_W      = 3,
  parameter int   UNLOCK_ONES = 5,
  parameter logic START_VAL   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_down,
  input  logic              wd_expire,
  input  logic              dat,
  input  logic              clk_rise,
  input  logic              clk_fall,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              err_stb
);
  localparam int FRAME_W = DATA_W + ADDR_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int ONES_W  = $clog2(UNLOCK_ONES + 1);

  srp_state_e         state;
  logic [ONES_W-1:0]  ones;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] shreg;
  logic               fall_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_LOCKED;
      ones     <= '0;
      bit_cnt  <= '0;
      shreg    <= '0;
      fall_val <= 1'b0;
      wr_stb   <= 1'b0;
      err_stb  <= 1'b0;
      wr_data  <= '0;
      wr_addr  <= '0;
    end else begin
      wr_stb  <= 1'b0;
      err_stb <= 1'b0;
      if (pwr_down || wd_expire) begin
        state   <= ST_LOCKED;
        ones    <= '0;
        bit_cnt <= '0;
      end else begin
        if (clk_fall) fall_val <= dat;
        if (clk_rise) begin
          case (state)
            ST_LOCKED: begin
              if (dat) begin
                if (ones != ONES_W'(UNLOCK_ONES)) ones <= ones + 1'b1;
              end else begin
                if (ones == ONES_W'(UNLOCK_ONES)) state <= ST_START;
                ones <= '0;
              end
            end
            ST_START: begin
              if (fall_val == dat) begin
                err_stb <= 1'b1;
                state   <= ST_LOCKED;
              end else if (dat == START_VAL) begin
                state   <= ST_SHIFT;
                bit_cnt <= '0;
              end else begin
                state <= ST_LOCKED;
              end
            end
            ST_SHIFT: begin
              if (fall_val != dat) begin
                shreg <= {dat, shreg[FRAME_W-1:1]};
                if (bit_cnt != CNT_W'(FRAME_W + 1)) bit_cnt <= bit_cnt + 1'b1;
              end else if (dat) begin
                state <= ST_LOCKED;
                if (bit_cnt == CNT_W'(FRAME_W)) begin
                  wr_stb  <= 1'b1;
                  wr_data <= shreg[DATA_W-1:0];
                  wr_addr <= shreg[FRAME_W-1:DATA_W];
                end else begin
                  err_stb <= 1'b1;
                end
              end else begin
                err_stb <= 1'b1;
                state   <= ST_LOCKED;
              end
            end
            default: state <= ST_LOCKED;
          endcase
        end
      end
    end
  end

  p_stb_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);
  p_err_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    err_stb |=> !err_stb);
  p_full_word_r5: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $past(bit_cnt) == CNT_W'(FRAME_W));
  p_timeout_relock_r6: assert property (@(posedge clk) disable iff (rst)
    wd_expire |=> state == ST_LOCKED);
  p_load_relock_r7: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> state == ST_LOCKED);
  p_pd_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> !wr_stb && !err_stb);
endmodule

// File: rtl/serial_reg_prog.sv
module serial_reg_prog #(
  parameter int   DATA_W      = 21,
  parameter int   ADDR_W      = 3,
  parameter int   UNLOCK_ONES = 5,
  parameter logic START_VAL   = 1'b0,
  parameter int   SYNC_STAGES = 2,
  parameter int   WDOG_CYCLES = 100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_down,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              err_stb
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] lines_in, lvl, rise, fall;
  logic              expire;

  assign lines_in = {ser_dat, ser_clk};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    srp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .line_in(lines_in[g]),
      .level(lvl[g]), .rise(rise[g]), .fall(fall[g])
    );
  end

  srp_watchdog #(.LIMIT(WDOG_CYCLES)) u_wdog (
    .clk(clk), .rst(rst), .activity(|(rise | fall)), .expire(expire)
  );

  srp_frame_core #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .UNLOCK_ONES(UNLOCK_ONES), .START_VAL(START_VAL)
  ) u_core (
    .clk(clk), .rst(rst), .pwr_down(pwr_down), .wd_expire(expire),
    .dat(lvl[1]), .clk_rise(rise[0]), .clk_fall(fall[0]),
    .wr_stb(wr_stb), .wr_data(wr_data), .wr_addr(wr_addr), .err_stb(err_stb)
  );
endmodule

// File: tb/test_serial_reg_prog.sv
module test_serial_reg_prog;
  localparam int WDOG = 64;
  localparam int HOLD = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_down = 1'b0;
  logic ser_clk = 1'b1;
  logic ser_dat = 1'b0;
  logic wr_stb, err_stb;
  logic [20:0] wr_data;
  logic [2:0]  wr_addr;

  int checks = 0;
  int errors = 0;
  logic [23:0] exp_wr[$];
  int exp_err = 0;
  logic prev_stb = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  serial_reg_prog #(.WDOG_CYCLES(WDOG)) i_serial_reg_prog (
    .clk(clk), .rst(rst), .pwr_down(pwr_down), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .wr_stb(wr_stb), .wr_data(wr_data), .wr_addr(wr_addr), .err_stb(err_stb)
  );

  // per-clock comparison against the expected event model
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_stb) begin
        checks++;
        if (prev_stb) begin
          errors++;
          $display("FAIL R3: strobe longer than one cycle, actual 1 expected 0");
        end else if (exp_wr.size() == 0) begin
          errors++;
          $display("FAIL R3/R7: unexpected write addr=%0d data=%h, expected none", wr_addr, wr_data);
        end else begin
          logic [23:0] e;
          e = exp_wr.pop_front();
          if ({wr_addr, wr_data} !== e) begin
            errors++;
            $display("FAIL R3: write actual %h expected %h", {wr_addr, wr_data}, e);
          end
        end
      end
      if (err_stb) begin
        checks++;
        if (exp_err == 0) begin
          errors++;
          $display("FAIL R4/R5/R9: unexpected error pulse, actual 1 expected 0");
        end else exp_err--;
      end
      prev_stb = wr_stb;
    end
  end

  task automatic line(input logic c, input logic d);
    @(negedge clk);
    ser_clk = c;
    ser_dat = d;
    repeat (HOLD - 1) @(negedge clk);
  endtask

  task automatic unlock(input int n);
    for (int i = 0; i < n; i++) begin
      line(1'b0, 1'b1);
      line(1'b1, 1'b1);
    end
    line(1'b0, 1'b0);
    line(1'b1, 1'b0);
  endtask

  task automatic send_bit(input logic v);
    line(1'b1, ~v);
    line(1'b0, ~v);
    line(1'b0, v);
    line(1'b1, v);
  endtask

  task automatic bad_pair();
    line(1'b1, 1'b0);
    line(1'b0, 1'b0);
    line(1'b1, 1'b0);
  endtask

  task automatic send_load();
    line(1'b1, 1'b1);
    line(1'b0, 1'b1);
    line(1'b1, 1'b1);
  endtask

  task automatic send_word(input logic [20:0] d, input logic [2:0] a, input int nd);
    send_bit(1'b0);
    for (int i = 0; i < nd; i++) send_bit(d[i % 21]);
    for (int i = 0; i < 3; i++) send_bit(a[i]);
  endtask

  task automatic settle(input string tag);
    repeat (12) @(negedge clk);
    checks++;
    if (exp_wr.size() != 0 || exp_err != 0) begin
      errors++;
      $display("FAIL %s: pending events actual writes=%0d errs=%0d expected 0 0",
               tag, exp_wr.size(), exp_err);
      exp_wr.delete();
      exp_err = 0;
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: bench hung, actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (wr_stb !== 1'b0 || err_stb !== 1'b0 || wr_data !== '0 || wr_addr !== '0) begin
      errors++;
      $display("FAIL R1: reset outputs actual %b%b %h %h expected 00 0 0",
               wr_stb, err_stb, wr_data, wr_addr);
    end

    // R3: basic writes, two addresses
    exp_wr.push_back({3'd2, 21'h12345});
    unlock(5); send_word(21'h12345, 3'd2, 21); send_load();
    settle("R3");
    exp_wr.push_back({3'd7, 21'h1FFFFF});
    unlock(8); send_word(21'h1FFFFF, 3'd7, 21); send_load();   // R2: longer run accepted
    settle("R2");
    exp_wr.push_back({3'd0, 21'h100001});
    unlock(5); send_word(21'h100001, 3'd0, 21); send_load();
    settle("R3");

    // R2: only four high edges, word ignored
    unlock(4); send_word(21'h0AAAAA, 3'd2, 21); send_load();
    settle("R2");

    // R7: word without a fresh unlock after a good load
    exp_wr.push_back({3'd1, 21'h00F0F0});
    unlock(5); send_word(21'h00F0F0, 3'd1, 21); send_load();
    send_word(21'h0AAAAA, 3'd2, 21); send_load();
    settle("R7");

    // R4: bad pair mid-word
    exp_err = 1;
    unlock(5); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); bad_pair();
    settle("R4");

    // R5: short and long words
    exp_err = 1;
    unlock(5); send_word(21'h055555, 3'd3, 20); send_load();
    settle("R5");
    exp_err = 1;
    unlock(5); send_word(21'h055555, 3'd3, 22); send_load();
    settle("R5");

    // R6: long pause drops the word, short pause does not
    unlock(5); send_bit(1'b0);
    for (int i = 0; i < 10; i++) send_bit(1'b0);
    repeat (WDOG + 30) @(negedge clk);
    for (int i = 0; i < 11; i++) send_bit(1'b0);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_load();
    settle("R6");
    exp_wr.push_back({3'd5, 21'h0});
    unlock(5); send_bit(1'b0);
    for (int i = 0; i < 10; i++) send_bit(1'b0);
    repeat (WDOG - 25) @(negedge clk);
    for (int i = 0; i < 11; i++) send_bit(1'b0);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_load();
    settle("R6");

    // R8: power-down blocks the link
    pwr_down = 1'b1;
    unlock(5); send_word(21'h054321, 3'd6, 21); send_load();
    pwr_down = 1'b0;
    settle("R8");

    // R9: wrong start value closes the link silently
    unlock(5); send_bit(1'b1);
    for (int i = 0; i < 21; i++) send_bit(1'b0);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_load();
    settle("R9");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule